// File: doc/BRIEF.md
# Two-level carry-lookahead adder

A 16-bit combinational adder that computes every carry in parallel instead of passing it bit to bit. The operands are split into four 4-bit groups. Inside each group, per-bit generate (`a & b`) and propagate (`a | b`) terms are expanded into flat sum-of-products carry equations. Each group also reduces its bits to one group generate and one group propagate.

A second lookahead unit of the same form takes the four group pairs and the overall carry-in. From them it produces the carry into every group and the final carry-out, again with no ripple between groups.

The block-level generate and propagate are brought out as ports. Four of these adders can then be joined by a third lookahead level into a 64-bit adder. The block has no clock and no state. Operands flow straight through, so there is no handshake and no back-pressure: the outputs follow the inputs after the combinational delay.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin` for every input combination.
- R2: `cout` equals bit 16 of the 17-bit result of `a + b + cin`.
- R3: `blk_gen` is 1 exactly when `a + b`, with no carry-in, exceeds 16'hFFFF.
- R4: `blk_prop` is 1 exactly when every bit position has at least one operand bit at 1, that is, when `a | b` equals 16'hFFFF.
- R5: Whenever `blk_gen` is 1, `cout` is 1, whatever the value of `cin`.
- R6: Whenever `blk_prop` is 1 and `blk_gen` is 0, `cout` equals `cin`.
- R7: A carry that enters at `cin` or arises in any group reaches every higher group. For example, `a`=16'hFFFF, `b`=0, `cin`=1 gives `sum`=0 and `cout`=1. Likewise, a carry generated in bits 3, 7 or 11 lands on the next group's lowest sum bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| cout | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Block propagate, for a higher lookahead level |
| blk_gen | output | 1 | Block generate, for a higher lookahead level |

## Verification
A wrong term in a group's carry equation shows as a sum bit flipped within that group. The error appears only for operand patterns whose carry chain passes through that term, so boundary patterns such as runs of ones across group edges are driven on purpose.

A wrong group-level term shows as the lowest sum bits of a higher group being wrong, or as a wrong `cout`. Because the block holds no state, every error is visible in the same settled evaluation as its stimulus. Each vector is therefore checked on its own, with nothing carried over to later vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_GROUP_W  = 4;
  localparam int unsigned CLA_N_GROUPS = 4;
  localparam int unsigned CLA_WIDTH    = CLA_GROUP_W * CLA_N_GROUPS;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);
  // Flat sum-of-products carries: no carry depends on another carry.
  always_comb begin
    logic term;
    logic acc;
    carry_o[0] = cin_i;
    for (int k = 1; k <= N; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = gen_i[j];
        for (int m = j + 1; m < k; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      term = cin_i;
      for (int m = 0; m < k; m++) term = term & prop_i[m];
      carry_o[k] = acc | term;
    end
  end

  always_comb begin
    logic term;
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int m = j + 1; m < N; m++) term = term & prop_i[m];
      acc = acc | term;
    end
    grp_gen_o  = acc;
    grp_prop_o = &prop_i;
  end

  always_comb begin
    AST_GRP_CARRY: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & cin_i))); // R6
    AST_GEN_FORCES_CARRY: assert (!grp_gen_o || carry_o[N]); // R5
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W:0]   carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_gen[i]  = a_i[i] & b_i[i];
    assign bit_prop[i] = a_i[i] | b_i[i];
    assign sum_o[i]    = a_i[i] ^ b_i[i] ^ carry[i];
  end

  cla_lookahead #(.N(W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (carry),
    .grp_prop_o (grp_prop_o),
    .grp_gen_o  (grp_gen_o)
  );

  always_comb begin
    AST_GROUP_SUM: assert ({carry[W], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i})); // R1
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
(
  input  logic [CLA_WIDTH-1:0] a,
  input  logic [CLA_WIDTH-1:0] b,
  input  logic                 cin,
  output logic [CLA_WIDTH-1:0] sum,
  output logic                 cout,
  output logic                 blk_prop,
  output logic                 blk_gen
);
  logic [CLA_N_GROUPS-1:0] grp_prop;
  logic [CLA_N_GROUPS-1:0] grp_gen;
  logic [CLA_N_GROUPS:0]   grp_carry;

  for (genvar k = 0; k < CLA_N_GROUPS; k++) begin : g_grp
    cla_group #(.W(CLA_GROUP_W)) u_grp (
      .a_i        (a[k*CLA_GROUP_W +: CLA_GROUP_W]),
      .b_i        (b[k*CLA_GROUP_W +: CLA_GROUP_W]),
      .cin_i      (grp_carry[k]),
      .sum_o      (sum[k*CLA_GROUP_W +: CLA_GROUP_W]),
      .grp_prop_o (grp_prop[k]),
      .grp_gen_o  (grp_gen[k])
    );
  end

  cla_lookahead #(.N(CLA_N_GROUPS)) u_top_la (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (cin),
    .carry_o    (grp_carry),
    .grp_prop_o (blk_prop),
    .grp_gen_o  (blk_gen)
  );

  assign cout = grp_carry[CLA_N_GROUPS];

  always_comb begin
    AST_FULL_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{CLA_WIDTH{1'b0}}, cin})); // R2
    AST_BLK_PROP: assert (!blk_prop || ((a | b) == {CLA_WIDTH{1'b1}})); // R4
    AST_BLK_GEN: assert (blk_gen == (({1'b0, a} + {1'b0, b}) > {1'b0, {CLA_WIDTH{1'b1}}})); // R3
  end
endmodule

// File: tb/sim_cla16_adder.sv
module sim_cla16_adder;
  logic        clk = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout, blk_prop, blk_gen;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cla16_adder u0 (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .blk_prop(blk_prop), .blk_gen(blk_gen)
  );

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", tag, act, exp, a, b, cin);
    end
  endtask

  // Apply one vector and check all outputs against values derived from the requirements.
  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    logic [16:0] full;
    logic [16:0] nocin;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    full  = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
    nocin = {1'b0, va} + {1'b0, vb};
    chk("R1 sum", {1'b0, sum}, {1'b0, full[15:0]});
    chk("R2 cout", {16'b0, cout}, {16'b0, full[16]});
    chk("R3 blk_gen", {16'b0, blk_gen}, {16'b0, nocin[16]});
    chk("R4 blk_prop", {16'b0, blk_prop}, {16'b0, ((va | vb) == 16'hFFFF)});
    if (nocin[16]) chk("R5 cout forced by generate", {16'b0, cout}, 17'd1);
    if (((va | vb) == 16'hFFFF) && !nocin[16]) chk("R6 cout follows cin", {16'b0, cout}, {16'b0, vc});
  endtask

  task automatic t_zero;
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R1 zero sum", {1'b0, sum}, 17'd0);
  endtask

  task automatic t_full_chain;
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R7 full chain sum", {1'b0, sum}, 17'd0);
    chk("R7 full chain cout", {16'b0, cout}, 17'd1);
    apply(16'h0000, 16'hFFFF, 1'b1);
    chk("R7 full chain swapped", {cout, sum}, 17'h10000);
    apply(16'hAAAA, 16'h5555, 1'b0);
    apply(16'hAAAA, 16'h5555, 1'b1);
  endtask

  task automatic t_group_edges;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] one = 16'h1 << (4*k + 3);
      apply(one, one, 1'b0);
      chk("R7 group edge carry", {1'b0, sum}, {1'b0, 16'h1 << (4*k + 4)});
    end
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h00FF, 16'h0000, 1'b1);
    apply(16'h0FFF, 16'h0001, 1'b0);
  endtask

  task automatic t_gen_prop;
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h8000, 16'h8000, 1'b1);
    apply(16'hF0F0, 16'h0F0F, 1'b0);
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    apply(16'hFFFE, 16'h0000, 1'b1);
  endtask

  task automatic t_random;
    logic [31:0] s = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      apply(s[15:0], s[31:16], s[7] ^ s[22]);
    end
  endtask

  initial begin
    t_zero();
    t_full_chain();
    t_group_edges();
    t_gen_prop();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule